// File: doc/BRIEF.md
# Cache Line Refill Controller with Early Restart

After a cache miss, this block refills one cache line from a word-wide memory port. A miss request carries a line address, the index of the word the processor wants, and a mode bit. The block sends one read request per word of the line, each tagged with its word index. It writes every returned word into its line buffer and keeps one valid bit per word.

In sequential mode the words are requested from index 0 upward. In critical-first mode the requested word is fetched first, and the remaining words follow in ascending order with that index skipped. In both modes the processor's load is acknowledged in the same cycle that its word arrives from memory, so the processor resumes while the rest of the line is still filling. A further load to another word of the same line stalls until that word is present and then completes without any new memory traffic. Once the fill ends, the line stays readable.

Top module: `line_refill`

## Requirements
- R1: While reset is asserted, miss_rdy_o is 1 and mem_req_o, cpu_ack_o and line_done_o are 0.
- R2: A miss is taken on a clock edge where miss_i and miss_rdy_o are both 1. From the next cycle, miss_rdy_o stays 0 until the cycle after the line_done_o pulse.
- R3: With cwf_i = 0 at the miss, the word indices on mem_idx_o are accepted in the order 0, 1, …, WORDS-1.
- R4: With cwf_i = 1 at the miss, the first accepted index is miss_idx_i. The remaining indices follow in ascending order with that index left out.
- R5: While mem_req_o is 1 and mem_gnt_i is 0, mem_req_o, mem_idx_o and mem_line_o hold their values. Responses are matched to requests in order, and each word is written exactly once per fill.
- R6: A held load (cpu_req_i with cpu_idx_i) of a word that is not yet present is acknowledged in the same cycle that mem_rvalid_i returns that word, with cpu_rdata_o equal to mem_rdata_i.
- R7: During a fill, a load of a word already present is acknowledged in the cycle it is raised. A load of a missing word waits for that word. A fill makes exactly WORDS memory requests.
- R8: line_done_o pulses high for exactly one cycle, in the cycle after the last word is written.
- R9: A load presented in the cycle a miss is taken is not acknowledged in that cycle.
- R10: While idle after a fill, a load of any word is acknowledged in the same cycle with the word stored for that index.
- R11: Throughout a fill, mem_line_o equals the miss_line_i value captured when the miss was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_i | input | 1 | Miss request |
| miss_line_i | input | LINE_W | Line address of the miss |
| miss_idx_i | input | log2(WORDS) | Index of the requested word |
| cwf_i | input | 1 | 1 = critical word first, 0 = sequential order |
| miss_rdy_o | output | 1 | Idle, ready to take a miss |
| cpu_req_i | input | 1 | Processor load, held until acknowledged |
| cpu_idx_i | input | log2(WORDS) | Word index of the load |
| cpu_ack_o | output | 1 | Load completes this cycle |
| cpu_rdata_o | output | WORD_W | Load data |
| mem_req_o | output | 1 | Word read request |
| mem_gnt_i | input | 1 | Request accepted at this edge |
| mem_line_o | output | LINE_W | Line address of the request |
| mem_idx_o | output | log2(WORDS) | Word index of the request |
| mem_rvalid_i | input | 1 | Response word valid, in request order |
| mem_rdata_i | input | WORD_W | Response word |
| line_done_o | output | 1 | One-cycle pulse when the line is complete |

## Verification
The hardest case to reach is a second load that chases the fill: it is raised right after the release and names a word that may have arrived already, may arrive in that very cycle, or may still be several responses away. The stimulus covers every requested index in both modes, then adds random cases in which the second index, a line address, and an initial grant stall of up to five cycles are all drawn at random. The memory model answers at fixed first-word and next-word latencies counted from the miss. The expected release cycle and the expected second acknowledge cycle therefore follow directly from each word's position in the fetch order.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} fill_st_e;
endpackage

// File: rtl/refill_order.sv
// Maps a fetch position to a word index for the selected order.
module refill_order #(
  parameter int WORDS = 8,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic             cwf_i,
  input  logic [IDX_W-1:0] crit_i,
  input  logic [CNT_W-1:0] pos_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [CNT_W-1:0] pos_m1;
  logic [CNT_W-1:0] crit_ext;

  assign pos_m1   = pos_i - CNT_W'(1);
  assign crit_ext = CNT_W'(crit_i);

  always_comb begin
    if (!cwf_i)                   idx_o = pos_i[IDX_W-1:0];
    else if (pos_i == '0)         idx_o = crit_i;
    else if (pos_m1 < crit_ext)   idx_o = pos_m1[IDX_W-1:0];
    else                          idx_o = pos_i[IDX_W-1:0];
  end
endmodule

// File: rtl/refill_buf.sv
// Line storage with per-word valid bits.
module refill_buf #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [WORDS-1:0]  vld_o
);
  logic [WORD_W-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] d_q;
    logic              v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else if (clr_i) begin
        v_q <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        d_q <= wr_data_i;
        v_q <= 1'b1;
      end
    end
    assign words[g] = d_q;
    assign vld_o[g] = v_q;
  end

  assign rd_data_o = words[rd_idx_i];

  // R5
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !vld_o[wr_idx_i]);
endmodule

// File: rtl/line_refill.sv
module line_refill #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  parameter int LINE_W = 27,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [LINE_W-1:0] miss_line_i,
  input  logic [IDX_W-1:0]  miss_idx_i,
  input  logic              cwf_i,
  output logic              miss_rdy_o,
  input  logic              cpu_req_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output logic              cpu_ack_o,
  output logic [WORD_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic [LINE_W-1:0] mem_line_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              line_done_o
);
  import refill_pkg::*;

  localparam logic [CNT_W-1:0] NWORDS = CNT_W'(WORDS);

  fill_st_e          st_q;
  logic [LINE_W-1:0] line_q;
  logic [IDX_W-1:0]  crit_q;
  logic              cwf_q;
  logic [CNT_W-1:0]  iss_q, rsp_q;
  logic [IDX_W-1:0]  rsp_idx;
  logic [WORD_W-1:0] buf_rdata;
  logic [WORDS-1:0]  vld;
  logic              busy, accept, wr_en, arrive_hit, done;

  assign busy   = (st_q == ST_FILL);
  assign accept = miss_i && (st_q == ST_IDLE);
  assign wr_en  = busy && mem_rvalid_i;
  assign done   = busy && (&vld);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      line_q <= '0;
      crit_q <= '0;
      cwf_q  <= 1'b0;
      iss_q  <= '0;
      rsp_q  <= '0;
    end else if (accept) begin
      st_q   <= ST_FILL;
      line_q <= miss_line_i;
      crit_q <= miss_idx_i;
      cwf_q  <= cwf_i;
      iss_q  <= '0;
      rsp_q  <= '0;
    end else if (busy) begin
      if (mem_req_o && mem_gnt_i) iss_q <= iss_q + CNT_W'(1);
      if (wr_en)                  rsp_q <= rsp_q + CNT_W'(1);
      if (done)                   st_q  <= ST_IDLE;
    end
  end

  // issue and response sides walk the same order independently
  refill_order #(.WORDS(WORDS)) u_iss_ord (
    .cwf_i (cwf_q),
    .crit_i(crit_q),
    .pos_i (iss_q),
    .idx_o (mem_idx_o)
  );

  refill_order #(.WORDS(WORDS)) u_rsp_ord (
    .cwf_i (cwf_q),
    .crit_i(crit_q),
    .pos_i (rsp_q),
    .idx_o (rsp_idx)
  );

  refill_buf #(.WORDS(WORDS), .WORD_W(WORD_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .wr_en_i  (wr_en),
    .wr_idx_i (rsp_idx),
    .wr_data_i(mem_rdata_i),
    .rd_idx_i (cpu_idx_i),
    .rd_data_o(buf_rdata),
    .vld_o    (vld)
  );

  assign mem_req_o   = busy && (iss_q < NWORDS);
  assign mem_line_o  = line_q;
  assign miss_rdy_o  = (st_q == ST_IDLE);
  assign line_done_o = done;

  // forward the arriving word straight to the processor
  assign arrive_hit  = wr_en && (rsp_idx == cpu_idx_i);
  assign cpu_ack_o   = cpu_req_i && !accept && (vld[cpu_idx_i] || arrive_hit);
  assign cpu_rdata_o = arrive_hit ? mem_rdata_i : buf_rdata;

  // R2
  miss_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && miss_rdy_o) |=> !miss_rdy_o);
  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> mem_req_o && $stable(mem_idx_o) && $stable(mem_line_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !line_done_o && miss_rdy_o);
  // R7
  no_extra_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> !mem_req_o);
endmodule

// File: tb/sim_line_refill.sv
module sim_line_refill;
  localparam int WORDS  = 8;
  localparam int WORD_W = 32;
  localparam int LINE_W = 27;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int FIRST_LAT = 8;
  localparam int NEXT_LAT  = 2;
  localparam int DONE_N = FIRST_LAT + (WORDS - 1) * NEXT_LAT + 1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              miss_i = 1'b0;
  logic [LINE_W-1:0] miss_line_i = '0;
  logic [IDX_W-1:0]  miss_idx_i = '0;
  logic              cwf_i = 1'b0;
  logic              miss_rdy_o;
  logic              cpu_req_i = 1'b0;
  logic [IDX_W-1:0]  cpu_idx_i = '0;
  logic              cpu_ack_o;
  logic [WORD_W-1:0] cpu_rdata_o;
  logic              mem_req_o;
  logic              mem_gnt_i = 1'b0;
  logic [LINE_W-1:0] mem_line_o;
  logic [IDX_W-1:0]  mem_idx_o;
  logic              mem_rvalid_i = 1'b0;
  logic [WORD_W-1:0] mem_rdata_i = '0;
  logic              line_done_o;

  int vec = 0, bad = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  line_refill #(.WORDS(WORDS), .WORD_W(WORD_W), .LINE_W(LINE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .miss_i(miss_i), .miss_line_i(miss_line_i),
    .miss_idx_i(miss_idx_i), .cwf_i(cwf_i), .miss_rdy_o(miss_rdy_o),
    .cpu_req_i(cpu_req_i), .cpu_idx_i(cpu_idx_i), .cpu_ack_o(cpu_ack_o),
    .cpu_rdata_o(cpu_rdata_o), .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i),
    .mem_line_o(mem_line_o), .mem_idx_o(mem_idx_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .line_done_o(line_done_o)
  );

  function automatic logic [WORD_W-1:0] wdat(int line, int i);
    return (WORD_W'(line) * 32'h9E3779B1) ^ (WORD_W'(i) << 24) ^ WORD_W'(i + 1);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_fill(int line, int crit, bit cwf, int stall, int idx2);
    int ord[WORDS];
    int pos_of[WORDS];
    int req_log[WORDS];
    int hs = 0, rsp = 0, extra = 0, line_bad = 0, order_bad = 0;
    int rel = -1, ack2 = -1, done_cnt = 0, done_n = -1, rdy_n = -1, phase = 0;
    int arr2, exp2, k = 0;
    logic [WORD_W-1:0] d_rel = '0, d_two = '0;
    string oreq;

    if (cwf) begin
      ord[0] = crit;
      k = 1;
      for (int i = 0; i < WORDS; i++) if (i != crit) begin ord[k] = i; k++; end
    end else begin
      for (int i = 0; i < WORDS; i++) ord[i] = i;
    end
    for (int i = 0; i < WORDS; i++) pos_of[ord[i]] = i;

    // cycle of miss acceptance
    miss_i = 1'b1; miss_line_i = LINE_W'(line); miss_idx_i = IDX_W'(crit); cwf_i = cwf;
    cpu_req_i = 1'b1; cpu_idx_i = IDX_W'(crit);
    mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0;
    #1;
    chk(miss_rdy_o == 1'b1, "R2 ready before miss", miss_rdy_o, 1);
    chk(cpu_ack_o == 1'b0, "R9 no ack in miss cycle", cpu_ack_o, 0);
    tick();
    miss_i = 1'b0;

    for (int n = 0; n <= DONE_N + 2; n++) begin
      mem_gnt_i = (n >= stall);
      mem_rvalid_i = 1'b0;
      if (rsp < WORDS && rsp < hs && n == FIRST_LAT + rsp * NEXT_LAT) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i = wdat(line, req_log[rsp]);
      end
      if (phase == 0) begin cpu_req_i = 1'b1; cpu_idx_i = IDX_W'(crit); end
      else if (phase == 1) begin cpu_req_i = 1'b1; cpu_idx_i = IDX_W'(idx2); end
      else cpu_req_i = 1'b0;
      #1;
      if (mem_req_o) begin
        if (mem_line_o != LINE_W'(line)) line_bad++;
        if (mem_gnt_i) begin
          if (hs < WORDS) req_log[hs] = int'(mem_idx_o);
          else extra++;
          hs++;
        end
      end
      if (mem_rvalid_i) rsp++;
      if (cpu_ack_o) begin
        if (phase == 0) begin rel = n; d_rel = cpu_rdata_o; phase = 1; end
        else if (phase == 1) begin ack2 = n; d_two = cpu_rdata_o; phase = 2; end
      end
      if (line_done_o) begin done_cnt++; done_n = n; end
      if (miss_rdy_o && rdy_n < 0) rdy_n = n;
      tick();
    end
    cpu_req_i = 1'b0; mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0;

    for (int i = 0; i < WORDS && i < hs; i++) if (req_log[i] != ord[i]) order_bad++;
    oreq = cwf ? "R4 fetch order" : "R3 fetch order";
    chk(order_bad == 0, oreq, order_bad, 0);
    chk(hs == WORDS && extra == 0, "R7 request count", hs, WORDS);
    chk(line_bad == 0, "R11 line address", line_bad, 0);
    chk(rel == FIRST_LAT + pos_of[crit] * NEXT_LAT, "R6 release cycle",
        rel, FIRST_LAT + pos_of[crit] * NEXT_LAT);
    chk(d_rel == wdat(line, crit), "R6 release data", d_rel, wdat(line, crit));
    arr2 = FIRST_LAT + pos_of[idx2] * NEXT_LAT;
    exp2 = (arr2 > rel + 1) ? arr2 : rel + 1;
    chk(ack2 == exp2, "R7 second load cycle", ack2, exp2);
    chk(d_two == wdat(line, idx2), "R7 second load data", d_two, wdat(line, idx2));
    chk(done_cnt == 1 && done_n == DONE_N, "R8 done pulse", done_n, DONE_N);
    chk(rdy_n == DONE_N + 1, "R2 ready return", rdy_n, DONE_N + 1);
  endtask

  initial begin
    int last_line = 0;
    void'($urandom(32'd4711));
    #1;
    chk(miss_rdy_o == 1'b1, "R1 rdy in reset", miss_rdy_o, 1);
    chk(!mem_req_o && !cpu_ack_o && !line_done_o, "R1 outputs in reset",
        {mem_req_o, cpu_ack_o, line_done_o}, 0);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    tick();

    // directed: every index in both modes
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < WORDS; c++) begin
        last_line = 100 + m * WORDS + c;
        do_fill(last_line, c, bit'(m), 0, (c + 3) % WORDS);
      end
    end
    // corner: last word sequential, second load equals first
    last_line = 7;
    do_fill(last_line, WORDS - 1, 1'b0, 5, WORDS - 1);
    // random
    for (int r = 0; r < 24; r++) begin
      last_line = int'($urandom() & ((1 << LINE_W) - 1));
      do_fill(last_line, int'($urandom_range(WORDS - 1)), bit'($urandom_range(1)),
              int'($urandom_range(5)), int'($urandom_range(WORDS - 1)));
    end

    // idle reads of retained line
    for (int i = 0; i < WORDS; i++) begin
      cpu_req_i = 1'b1; cpu_idx_i = IDX_W'(i);
      #1;
      chk(cpu_ack_o == 1'b1 && cpu_rdata_o == wdat(last_line, i), "R10 idle read",
          cpu_rdata_o, wdat(last_line, i));
      tick();
    end
    cpu_req_i = 1'b0;

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      vec++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule